// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers up to 63 interrupt requests and offers the CPU a single one: the most urgent request that software has left unmasked. There are 56 sources whose level (three bits) and priority within that level (three bits) software sets, and 7 sources whose levels are fixed in hardware. Each fixed source sits at a level of its own, from 1 to 7, and within that level it ranks above every programmable source. With 8 programmable priorities plus the fixed source, one level holds up to 9 ranked requests.

Software controls the block with one command per cycle. A command names an operation and a source index: set or clear a mask bit, set or clear a force bit (a force bit raises that source's request from software), or set a programmable source's level and priority. Index 63 selects the global mask instead of a source. Masks change without read-modify-write. The command strobe has no back-pressure: every strobed command takes effect at the next clock edge.

Each cycle the block compares the winning level with the CPU's current mask level. It presents the level and the vector number (64 plus the source index) when the level is above the CPU's mask level, or when it is level 7, which cannot be masked out by the CPU. During an interrupt acknowledge the CPU supplies a level, and one cycle later the block returns the vector of the winning source at that level, or the spurious vector 24 when no source is pending there.

Top module: `intc_ctrl`

## Requirements
- R1: After reset every source mask bit and the global mask are set and all force bits are clear, so irq_level and irq_vector read 0 even with every source requesting; reset is synchronous and active high.
- R2: Among the sources that may be presented, the highest level wins.
- R3: Within the winning level the highest priority wins. Fixed sources have priority 8, above the programmable range 0..7. On a remaining tie the lowest source index wins.
- R4: The winner is presented only when its level is above cpu_ipl, or when its level is 7. Level 7 is presented even when cpu_ipl is 7.
- R5: cmd_op 1 sets and cmd_op 2 clears the mask bit of source cmd_idx (0..62). A masked source is never presented and never acknowledged.
- R6: cmd_op 1 and cmd_op 2 with cmd_idx 63 set and clear the global mask. While the global mask is set, only sources at level 7 are presented or acknowledged.
- R7: cmd_op 3 sets and cmd_op 4 clears the force bit of source cmd_idx. A forced source requests as if its src_req bit were high.
- R8: When iack_req is high, the next cycle iack_vld is 1 and iack_vector is 64 plus the index of the winning unmasked pending source at iack_level, using the R3 ranking and ignoring cpu_ipl. When iack_req is low, the next cycle iack_vld and iack_vector are 0.
- R9: When no eligible source is pending at iack_level (iack_level 0 included), iack_vector is the spurious value 24.
- R10: Source 56+k (k = 0..6) has the fixed level k+1. cmd_op 5 writes cmd_lvl and cmd_pri for sources 0..55 only; for indices 56..63 it has no effect.
- R11: A programmable source at level 0 is never presented and never acknowledged.
- R12: irq_level and irq_vector are registered. They reflect the inputs and control state at the previous clock edge, and both read 0 when nothing is presented. Any cmd_op above 5 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, accepted every cycle |
| cmd_op | input | 3 | Operation: 1 mask set, 2 mask clear, 3 force set, 4 force clear, 5 configure |
| cmd_idx | input | 6 | Source index; 63 selects the global mask |
| cmd_lvl | input | 3 | Level for configure |
| cmd_pri | input | 3 | Priority for configure |
| src_req | input | 63 | Request lines from the sources, active high |
| cpu_ipl | input | 3 | CPU current mask level |
| iack_req | input | 1 | Acknowledge request |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Presented level, 0 when none |
| irq_vector | output | 8 | Presented vector, 0 when none |
| iack_vld | output | 1 | Acknowledge response valid |
| iack_vector | output | 8 | Acknowledged vector or 24 |

## Verification
The assertions take no constraint on cpu_ipl, iack_level or cmd_idx: they are meant to hold for any value, including out-of-range indices and reserved operation codes. What they do assume is that reset stays high for at least two clock edges, so that the delayed copies of the mask state inside the checker start from the reset values. The bench holds reset for four cycles. After that it feeds directed patterns followed by long stretches of fully random commands, requests, mask levels and acknowledges. These random inputs cover indices 63 and 56..62 as well as op codes 6 and 7.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_MASK_SET = 3'd1,
    OP_MASK_CLR = 3'd2,
    OP_FRC_SET  = 3'd3,
    OP_FRC_CLR  = 3'd4,
    OP_CFG      = 3'd5
  } intc_op_e;

endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NUM_PROG  = 56,
  parameter int NUM_FIXED = 7,
  parameter int LVL_W     = 3,
  parameter int PRI_W     = 3,
  localparam int NS       = NUM_PROG + NUM_FIXED,
  localparam int IDX_W    = $clog2(NS + 1),
  localparam int PW       = PRI_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [IDX_W-1:0]           cmd_idx,
  input  logic [LVL_W-1:0]           cmd_lvl,
  input  logic [PRI_W-1:0]           cmd_pri,
  output logic [NS-1:0]              mask_q,
  output logic                       gmask_q,
  output logic [NS-1:0]              force_q,
  output logic [NS-1:0][LVL_W-1:0]   src_lvl,
  output logic [NS-1:0][PW-1:0]      src_pri
);
  import intc_pkg::*;

  localparam logic [IDX_W-1:0] GLOBAL_IDX = '1;
  localparam logic [PW-1:0]    FIXED_PRI  = PW'(1 << PRI_W);

  intc_op_e op;
  logic     idx_src;
  logic     idx_prog;

  logic [LVL_W-1:0] prog_lvl [NUM_PROG];
  logic [PRI_W-1:0] prog_pri [NUM_PROG];

  assign op       = intc_op_e'(cmd_op);
  assign idx_src  = int'(cmd_idx) < NS;
  assign idx_prog = int'(cmd_idx) < NUM_PROG;

  // mask and global mask, changed only by indexed set/clear
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
    end else if (cmd_valid) begin
      if (op == OP_MASK_SET) begin
        if (cmd_idx == GLOBAL_IDX) gmask_q <= 1'b1;
        else if (idx_src)          mask_q[cmd_idx] <= 1'b1;
      end else if (op == OP_MASK_CLR) begin
        if (cmd_idx == GLOBAL_IDX) gmask_q <= 1'b0;
        else if (idx_src)          mask_q[cmd_idx] <= 1'b0;
      end
    end
  end

  // software force bits
  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= '0;
    end else if (cmd_valid && idx_src) begin
      if (op == OP_FRC_SET)      force_q[cmd_idx] <= 1'b1;
      else if (op == OP_FRC_CLR) force_q[cmd_idx] <= 1'b0;
    end
  end

  // programmable level / priority table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PROG; i++) begin
        prog_lvl[i] <= '0;
        prog_pri[i] <= '0;
      end
    end else if (cmd_valid && op == OP_CFG && idx_prog) begin
      prog_lvl[cmd_idx] <= cmd_lvl;
      prog_pri[cmd_idx] <= cmd_pri;
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_src
    if (i < NUM_PROG) begin : g_prog
      assign src_lvl[i] = prog_lvl[i];
      assign src_pri[i] = {1'b0, prog_pri[i]};
    end else begin : g_fixed
      assign src_lvl[i] = LVL_W'(i - NUM_PROG + 1);
      assign src_pri[i] = FIXED_PRI;
    end
  end

endmodule

// File: rtl/intc_max_tree.sv
module intc_max_tree #(
  parameter int N      = 63,
  parameter int KW     = 7,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int NP    = 1 << IW
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][KW-1:0] key,
  output logic                 any,
  output logic [IW-1:0]        win_idx,
  output logic [KW-1:0]        win_key
);
  logic          nv [1:2*NP-1];
  logic [KW-1:0] nk [1:2*NP-1];
  logic [IW-1:0] ni [1:2*NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nv[NP+i] = valid[i];
      assign nk[NP+i] = key[i];
    end else begin : g_pad
      assign nv[NP+i] = 1'b0;
      assign nk[NP+i] = '0;
    end
    assign ni[NP+i] = IW'(i);
  end

  // right (higher index) child wins only on a strictly larger key
  for (genvar j = 1; j < NP; j++) begin : g_node
    logic take_r;
    assign take_r = nv[2*j+1] && (!nv[2*j] || (nk[2*j+1] > nk[2*j]));
    assign nv[j]  = nv[2*j] | nv[2*j+1];
    assign nk[j]  = take_r ? nk[2*j+1] : nk[2*j];
    assign ni[j]  = take_r ? ni[2*j+1] : ni[2*j];
  end

  assign any     = nv[1];
  assign win_idx = ni[1];
  assign win_key = nk[1];

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int NUM_PROG  = 56,
  parameter int NUM_FIXED = 7,
  parameter int LVL_W     = 3,
  parameter int PRI_W     = 3,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 64,
  parameter int VEC_SPUR  = 24,
  localparam int NS       = NUM_PROG + NUM_FIXED,
  localparam int IDX_W    = $clog2(NS + 1),
  localparam int PW       = PRI_W + 1,
  localparam int KW       = LVL_W + PW,
  localparam int TW       = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [LVL_W-1:0] cmd_lvl,
  input  logic [PRI_W-1:0] cmd_pri,
  input  logic [NS-1:0]    src_req,
  input  logic [LVL_W-1:0] cpu_ipl,
  input  logic             iack_req,
  input  logic [LVL_W-1:0] iack_level,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector,
  output logic             iack_vld,
  output logic [VEC_W-1:0] iack_vector
);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;

  logic [NS-1:0]            mask_q;
  logic                     gmask_q;
  logic [NS-1:0]            force_q;
  logic [NS-1:0][LVL_W-1:0] src_lvl;
  logic [NS-1:0][PW-1:0]    src_pri;

  intc_regs #(
    .NUM_PROG (NUM_PROG),
    .NUM_FIXED(NUM_FIXED),
    .LVL_W    (LVL_W),
    .PRI_W    (PRI_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_idx  (cmd_idx),
    .cmd_lvl  (cmd_lvl),
    .cmd_pri  (cmd_pri),
    .mask_q   (mask_q),
    .gmask_q  (gmask_q),
    .force_q  (force_q),
    .src_lvl  (src_lvl),
    .src_pri  (src_pri)
  );

  logic [NS-1:0]         pend;
  logic [NS-1:0]         present;
  logic [NS-1:0]         ack_hit;
  logic [NS-1:0][KW-1:0] pres_key;
  logic [NS-1:0][KW-1:0] ack_key;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      pend[i]     = (src_req[i] | force_q[i]) & ~mask_q[i]
                    & (~gmask_q | (src_lvl[i] == NMI_LVL))
                    & (src_lvl[i] != '0);
      present[i]  = pend[i] & ((src_lvl[i] > cpu_ipl) | (src_lvl[i] == NMI_LVL));
      ack_hit[i]  = pend[i] & (src_lvl[i] == iack_level);
      pres_key[i] = {src_lvl[i], src_pri[i]};
      ack_key[i]  = {{LVL_W{1'b0}}, src_pri[i]};
    end
  end

  logic          p_any, a_any;
  logic [TW-1:0] p_idx, a_idx;
  logic [KW-1:0] p_key, a_key;

  intc_max_tree #(.N(NS), .KW(KW)) u_pres_tree (
    .valid  (present),
    .key    (pres_key),
    .any    (p_any),
    .win_idx(p_idx),
    .win_key(p_key)
  );

  intc_max_tree #(.N(NS), .KW(KW)) u_ack_tree (
    .valid  (ack_hit),
    .key    (ack_key),
    .any    (a_any),
    .win_idx(a_idx),
    .win_key(a_key)
  );

  logic unused_key;
  assign unused_key = ^{a_key, p_key[PW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level   <= '0;
      irq_vector  <= '0;
      iack_vld    <= 1'b0;
      iack_vector <= '0;
    end else begin
      if (p_any) begin
        irq_level  <= p_key[KW-1:PW];
        irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(p_idx);
      end else begin
        irq_level  <= '0;
        irq_vector <= '0;
      end
      iack_vld <= iack_req;
      if (!iack_req)  iack_vector <= '0;
      else if (a_any) iack_vector <= VEC_W'(VEC_BASE) + VEC_W'(a_idx);
      else            iack_vector <= VEC_W'(VEC_SPUR);
    end
  end

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_PROG = 56,
  parameter int NUM_FIXED = 7,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  localparam int NS      = NUM_PROG + NUM_FIXED,
  localparam int IDX_W   = $clog2(NS + 1),
  localparam int MW      = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] cpu_ipl,
  input logic [LVL_W-1:0] irq_level,
  input logic [VEC_W-1:0] irq_vector,
  input logic             iack_req,
  input logic             iack_vld,
  input logic [VEC_W-1:0] iack_vector,
  input logic [NS-1:0]    mask_q,
  input logic             gmask_q
);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;

  logic [MW-1:0] mask_d;
  logic          gmask_d;
  int            vec_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d  <= '1;
      gmask_d <= 1'b1;
    end else begin
      mask_d  <= MW'(mask_q);
      gmask_d <= gmask_q;
    end
  end

  assign vec_off = int'(irq_vector) - VEC_BASE;

  p_ipl_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> ((irq_level > $past(cpu_ipl)) || (irq_level == NMI_LVL)));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> !mask_d[irq_vector[IDX_W-1:0]]);

  p_global_mask_r6: assert property (@(posedge clk) disable iff (rst)
    ((irq_level != '0) && gmask_d) |-> (irq_level == NMI_LVL));

  p_ack_follows_r8: assert property (@(posedge clk) disable iff (rst)
    iack_req |=> iack_vld);

  p_ack_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !iack_req |=> (!iack_vld && (iack_vector == '0)));

  p_ack_range_r9: assert property (@(posedge clk) disable iff (rst)
    iack_vld |-> ((int'(iack_vector) == VEC_SPUR) ||
                  ((int'(iack_vector) >= VEC_BASE) && (int'(iack_vector) < VEC_BASE + NS))));

  p_fixed_level_r10: assert property (@(posedge clk) disable iff (rst)
    ((irq_level != '0) && (vec_off >= NUM_PROG)) |-> (int'(irq_level) == vec_off - NUM_PROG + 1));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_level == '0) |-> (irq_vector == '0));

  p_vec_range_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> ((vec_off >= 0) && (vec_off < NS)));

endmodule

bind intc_ctrl intc_checker #(
  .NUM_PROG (NUM_PROG),
  .NUM_FIXED(NUM_FIXED),
  .LVL_W    (LVL_W),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_SPUR (VEC_SPUR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ipl    (cpu_ipl),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .iack_req   (iack_req),
  .iack_vld   (iack_vld),
  .iack_vector(iack_vector),
  .mask_q     (mask_q),
  .gmask_q    (gmask_q)
);

// File: tb/sim_intc_ctrl.sv
`timescale 1ns/1ps
module sim_intc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [5:0]  cmd_idx = '0;
  logic [2:0]  cmd_lvl = '0;
  logic [2:0]  cmd_pri = '0;
  logic [62:0] src_req = '0;
  logic [2:0]  cpu_ipl = '0;
  logic        iack_req = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  logic        iack_vld;
  logic [7:0]  iack_vector;

  always #2.5 clk = ~clk;

  intc_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_lvl(cmd_lvl), .cmd_pri(cmd_pri),
    .src_req(src_req), .cpu_ipl(cpu_ipl), .iack_req(iack_req),
    .iack_level(iack_level), .irq_level(irq_level), .irq_vector(irq_vector),
    .iack_vld(iack_vld), .iack_vector(iack_vector)
  );

  // behavioural reference state
  int    m_lvl [63];
  int    m_pri [63];
  bit    m_mask [63];
  bit    m_frc [63];
  bit    m_gm;
  int    e_lvl, e_vec, e_av, e_avec;
  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 63; i++) begin
      m_lvl[i]  = (i < 56) ? 0 : i - 55;
      m_pri[i]  = (i < 56) ? 0 : 8;
      m_mask[i] = 1'b1;
      m_frc[i]  = 1'b0;
    end
    m_gm = 1'b1;
  endfunction

  function automatic bit eligible(int i);
    return (src_req[i] || m_frc[i]) && !m_mask[i] && (!m_gm || m_lvl[i] == 7) && m_lvl[i] != 0;
  endfunction

  function automatic void predict();
    int best;
    int bp;
    if (rst) begin
      e_lvl = 0; e_vec = 0; e_av = 0; e_avec = 0;
      return;
    end
    best = -1; e_lvl = 0; e_vec = 0;
    for (int i = 0; i < 63; i++)
      if (eligible(i) && (m_lvl[i] > int'(cpu_ipl) || m_lvl[i] == 7))
        if (m_lvl[i] * 16 + m_pri[i] > best) begin
          best  = m_lvl[i] * 16 + m_pri[i];
          e_lvl = m_lvl[i];
          e_vec = 64 + i;
        end
    e_av = iack_req ? 1 : 0;
    e_avec = 0;
    if (iack_req) begin
      e_avec = 24; bp = -1;
      for (int i = 0; i < 63; i++)
        if (eligible(i) && m_lvl[i] == int'(iack_level) && m_pri[i] > bp) begin
          bp = m_pri[i];
          e_avec = 64 + i;
        end
    end
  endfunction

  function automatic void model_update();
    int ix;
    if (rst) begin
      model_reset();
      return;
    end
    if (!cmd_valid) return;
    ix = int'(cmd_idx);
    case (cmd_op)
      3'd1: if (ix == 63) m_gm = 1'b1; else m_mask[ix] = 1'b1;
      3'd2: if (ix == 63) m_gm = 1'b0; else m_mask[ix] = 1'b0;
      3'd3: if (ix < 63) m_frc[ix] = 1'b1;
      3'd4: if (ix < 63) m_frc[ix] = 1'b0;
      3'd5: if (ix < 56) begin m_lvl[ix] = int'(cmd_lvl); m_pri[ix] = int'(cmd_pri); end
      default: ;
    endcase
  endfunction

  // inputs are already set; predict, advance model, compare after the edge
  task automatic cycle();
    predict();
    model_update();
    @(negedge clk);
    n_vec++;
    if (int'(irq_level) != e_lvl || int'(irq_vector) != e_vec ||
        int'(iack_vld) != e_av || int'(iack_vector) != e_avec) begin
      n_bad++;
      $display("FAIL %s: got lvl=%0d vec=%0d ackv=%0d ackvec=%0d expected lvl=%0d vec=%0d ackv=%0d ackvec=%0d",
               cur_req, irq_level, irq_vector, iack_vld, iack_vector, e_lvl, e_vec, e_av, e_avec);
    end
  endtask

  task automatic cmd(input int op, input int idx, input int lv, input int pr);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = 6'(idx);
    cmd_lvl = 3'(lv); cmd_pri = 3'(pr);
    cycle();
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic src_only(input int a, input int b, input int c);
    src_req = '0;
    if (a >= 0) src_req[a] = 1'b1;
    if (b >= 0) src_req[b] = 1'b1;
    if (c >= 0) src_req[c] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] r;
    model_reset();
    @(negedge clk);
    // R1: reset state with all sources requesting
    cur_req = "R1";
    src_req = '1;
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(3);
    iack_req = 1'b1; iack_level = 3'd7;
    idle(2);
    iack_req = 1'b0;

    // R10: configure programmable sources; writes to fixed indices ignored
    cur_req = "R10";
    for (int i = 0; i < 56; i++) cmd(5, i, i % 8, (i * 3) % 8);
    cmd(5, 58, 1, 0);
    cmd(5, 63, 2, 2);

    // R6: unmask all sources, global mask still set
    cur_req = "R6";
    for (int i = 0; i < 63; i++) cmd(2, i, 0, 0);
    idle(2);
    cpu_ipl = 3'd7;
    idle(2);
    cpu_ipl = 3'd0;
    cmd(2, 63, 0, 0);
    idle(2);
    cmd(1, 63, 0, 0);
    idle(1);
    cmd(2, 63, 0, 0);

    // R2: highest level wins
    cur_req = "R2";
    src_only(1, 3, 13); idle(2);
    src_only(1, 3, -1); idle(2);
    src_only(1, -1, -1); idle(2);

    // R3: priority within level, fixed above programmable, lowest index on ties
    cur_req = "R3";
    cmd(5, 10, 4, 5); cmd(5, 20, 4, 5); cmd(5, 30, 4, 2);
    src_only(10, 20, 30); idle(2);
    src_only(20, 30, -1); idle(2);
    src_only(30, -1, -1); idle(2);
    src_only(10, 59, -1); idle(2);

    // R4: CPU mask level gating, level 7 always presented
    cur_req = "R4";
    src_only(3, -1, -1);
    for (int l = 0; l < 8; l++) begin cpu_ipl = 3'(l); idle(1); end
    src_only(3, 62, -1);
    for (int l = 0; l < 8; l++) begin cpu_ipl = 3'(l); idle(1); end
    cpu_ipl = 3'd0;

    // R5: per-source mask set and clear by index
    cur_req = "R5";
    src_only(10, 20, -1); idle(1);
    cmd(1, 10, 0, 0); idle(2);
    cmd(1, 20, 0, 0); idle(2);
    cmd(2, 10, 0, 0); idle(2);

    // R7: force bits
    cur_req = "R7";
    src_req = '0; idle(1);
    cmd(3, 13, 0, 0); idle(2);
    cmd(3, 62, 0, 0); idle(1);
    cmd(4, 62, 0, 0); cmd(4, 13, 0, 0); idle(2);

    // R8 / R9: acknowledge at every level
    cur_req = "R8";
    src_only(10, 20, 13);
    cpu_ipl = 3'd6;
    iack_req = 1'b1;
    for (int l = 0; l < 8; l++) begin
      cur_req = (l == 4 || l == 5) ? "R8" : "R9";
      iack_level = 3'(l); idle(1);
    end
    iack_req = 1'b0; cpu_ipl = 3'd0; idle(1);

    // R11: level-0 source silent
    cur_req = "R11";
    cmd(5, 40, 0, 7);
    src_only(40, -1, -1); idle(2);
    iack_req = 1'b1; iack_level = 3'd0; idle(1);
    iack_req = 1'b0; idle(1);

    // R12: random traffic, reserved op codes included
    cur_req = "R12";
    for (int n = 0; n < 4000; n++) begin
      r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      src_req   = r[62:0];
      cpu_ipl   = 3'($urandom);
      iack_req  = 1'($urandom);
      iack_level = 3'($urandom);
      cmd_valid = 1'($urandom);
      cmd_op    = 3'($urandom);
      cmd_idx   = 6'($urandom);
      cmd_lvl   = 3'($urandom);
      cmd_pri   = 3'($urandom);
      cycle();
    end
    cmd_valid = 1'b0; iack_req = 1'b0;
    idle(2);

    summary();
    $finish;
  end

endmodule